// File: doc/BRIEF.md
# Write-Through Update-Coherent Cache Controller

This block is the per-processor cache controller in a shared-memory system kept coherent by a home directory that pushes updates to sharers. The cache is direct-mapped and write-through, and a store miss allocates no line. A line is either invalid or a read-only copy; there is no owned or exclusive state. The processor side offers loads and stores one at a time. The home side has one outgoing request port, which carries read and write requests, and one incoming message port, which carries read replies, write replies and pushed word updates.

A load miss sends a read request and waits for the whole block. The block is installed and the requested word is returned. Every store sends its single word to the home. If the block is resident, the controller waits for the write reply and only then patches the word into its copy. If the block is not resident, the store finishes as soon as the request is sent. A pushed update patches one word of a resident line and is dropped if the block is absent. A line is replaced without any message to the home.

Top module: `wtu_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `home_req_valid` are 0. The first load of any address therefore misses.
- R2: A load that hits raises `cpu_rsp_valid` in the cycle after acceptance and returns the resident word on `cpu_rsp_rdata`. No outgoing message is sent.
- R3: A load that misses drives one read request in the cycle after acceptance, with `home_req_kind`=0 and the load address on `home_req_addr`. `cpu_req_ready` stays 0 until a read reply (`home_msg_kind`=0) for the same block arrives. The reply carries word k of the block in bits [k*DATA_W +: DATA_W] of `home_msg_data`. In the cycle after the reply, the block is installed and the requested word is returned.
- R4: Every accepted store drives one write request in the cycle after acceptance, with `home_req_kind`=1, the store address and the store word.
- R5: A store that misses responds in the cycle after acceptance and allocates no line, so a later load of that address still misses.
- R6: A store that hits keeps `cpu_rsp_valid` and `cpu_req_ready` at 0 until a write reply (`home_msg_kind`=1) for its block arrives. At that reply the reply's word (low DATA_W bits) is written into the line, and the response follows one cycle later.
- R7: An update (`home_msg_kind`=2) for a resident block overwrites only the addressed word of that line, using the low DATA_W bits of `home_msg_data`.
- R8: An update for a block that is not resident changes no line and produces no message or response.
- R9: Replacing a valid line on a fill sends no message to the home. The replaced block misses on its next load.
- R10: While a store waits for its write reply, updates are applied in arrival order and no new processor request is accepted.
- R11: When a load hit and an update to the same word fall in the same cycle, the load returns the value held before the update. Later loads see the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store word |
| cpu_req_ready | output | 1 | Controller can accept a request this cycle |
| cpu_rsp_valid | output | 1 | Request completed (one-cycle pulse) |
| cpu_rsp_rdata | output | DATA_W | Load result |
| home_req_valid | output | 1 | Outgoing request valid (one cycle) |
| home_req_kind | output | 1 | 0 = read request, 1 = write request |
| home_req_addr | output | ADDR_W | Request word address |
| home_req_word | output | DATA_W | Store word carried by a write request |
| home_msg_valid | input | 1 | Incoming message valid |
| home_msg_kind | input | 2 | 0 = read reply, 1 = write reply, 2 = update |
| home_msg_addr | input | ADDR_W | Message word address |
| home_msg_data | input | WORDS*DATA_W | Block for read reply, word in low bits otherwise |

## Verification
Two events can fall in the same edge: a processor access to the tag array, and an incoming update that patches the same array. The bench provokes this in two ways. It issues a load hit and an update to the same word in one cycle and expects the old word back, then the new word from the next load. It also injects an update while a store hit waits for its reply, with a competing load held on the request lines; it expects that load to be refused and both writes to be visible afterwards. Random runs mix loads, stores and updates over 16 blocks mapped onto 8 lines, so conflicts, silent evictions and updates to dropped blocks all occur. Each result is judged against a bench model of home memory and resident tags.

// File: rtl/wtu_pkg.sv
package wtu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RDWAIT = 2'd1,
        ST_WRWAIT = 2'd2
    } wtu_state_e;

    localparam logic       OUT_READ    = 1'b0;
    localparam logic       OUT_WRITE   = 1'b1;
    localparam logic [1:0] IN_READREP  = 2'd0;
    localparam logic [1:0] IN_WRITEREP = 2'd1;
    localparam logic [1:0] IN_UPDATE   = 2'd2;
endpackage

// File: rtl/wtu_addr_split.sv
module wtu_addr_split #(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 3,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [OFF_W-1:0]  off,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    assign off = addr[OFF_W-1:0];
    assign idx = addr[OFF_W+IDX_W-1:OFF_W];
    assign tag = addr[ADDR_W-1:OFF_W+IDX_W];
endmodule

// File: rtl/wtu_line_store.sv
module wtu_line_store #(
    parameter int LINES    = 8,
    parameter int WORDS    = 4,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 7,
    parameter int RD_PORTS = 2,
    localparam int IDX_W   = $clog2(LINES),
    localparam int OFF_W   = $clog2(WORDS),
    localparam int LINE_W  = WORDS * DATA_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [RD_PORTS-1:0][IDX_W-1:0]     rd_idx,
    output logic [RD_PORTS-1:0]                rd_vld,
    output logic [RD_PORTS-1:0][TAG_W-1:0]     rd_tag,
    output logic [RD_PORTS-1:0][LINE_W-1:0]    rd_line,
    input  logic                               fill_en,
    input  logic                               patch_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [TAG_W-1:0]                   wr_tag,
    input  logic [OFF_W-1:0]                   wr_off,
    input  logic [LINE_W-1:0]                  wr_line,
    input  logic [DATA_W-1:0]                  wr_word
);
    typedef struct packed {
        logic [LINES-1:0]             vld;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][LINE_W-1:0] dat;
    } arr_t;

    arr_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        if (fill_en) begin
            arr_d.vld[wr_idx] = 1'b1;
            arr_d.tag[wr_idx] = wr_tag;
            arr_d.dat[wr_idx] = wr_line;
        end else if (patch_en) begin
            arr_d.dat[wr_idx][int'(wr_off)*DATA_W +: DATA_W] = wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arr_q <= '0;
        else        arr_q <= arr_d;
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_vld[p]  = arr_q.vld[rd_idx[p]];
        assign rd_tag[p]  = arr_q.tag[rd_idx[p]];
        assign rd_line[p] = arr_q.dat[rd_idx[p]];
    end
endmodule

// File: rtl/wtu_cache_ctrl.sv
module wtu_cache_ctrl #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int WORDS   = 4,
    parameter int LINES   = 8,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              home_req_valid,
    output logic              home_req_kind,
    output logic [ADDR_W-1:0] home_req_addr,
    output logic [DATA_W-1:0] home_req_word,
    input  logic              home_msg_valid,
    input  logic [1:0]        home_msg_kind,
    input  logic [ADDR_W-1:0] home_msg_addr,
    input  logic [LINE_W-1:0] home_msg_data
);
    import wtu_pkg::*;

    typedef struct packed {
        wtu_state_e        st;
        logic [ADDR_W-1:0] pend;
        logic              o_vld;
        logic              o_kind;
        logic [ADDR_W-1:0] o_addr;
        logic [DATA_W-1:0] o_word;
        logic              r_vld;
        logic [DATA_W-1:0] r_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    function automatic logic [DATA_W-1:0] pick(input logic [LINE_W-1:0] ln,
                                               input logic [OFF_W-1:0]  o);
        return ln[int'(o)*DATA_W +: DATA_W];
    endfunction

    // address fields of the processor request, the incoming message and the pending request
    logic [OFF_W-1:0] cpu_off, msg_off, pend_off;
    logic [IDX_W-1:0] cpu_idx, msg_idx, pend_idx;
    logic [TAG_W-1:0] cpu_tag, msg_tag, pend_tag;

    wtu_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_cpu (
        .addr(cpu_req_addr), .off(cpu_off), .idx(cpu_idx), .tag(cpu_tag));
    wtu_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_msg (
        .addr(home_msg_addr), .off(msg_off), .idx(msg_idx), .tag(msg_tag));
    wtu_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_pend (
        .addr(ctl_q.pend), .off(pend_off), .idx(pend_idx), .tag(pend_tag));

    logic [1:0][IDX_W-1:0]  rd_idx;
    logic [1:0]             rd_vld;
    logic [1:0][TAG_W-1:0]  rd_tag;
    logic [1:0][LINE_W-1:0] rd_line;
    logic                   fill_en, patch_en;

    assign rd_idx[0] = cpu_idx;
    assign rd_idx[1] = msg_idx;

    wtu_line_store #(
        .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W), .RD_PORTS(2)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_line(rd_line),
        .fill_en(fill_en), .patch_en(patch_en),
        .wr_idx(msg_idx), .wr_tag(msg_tag), .wr_off(msg_off),
        .wr_line(home_msg_data), .wr_word(home_msg_data[DATA_W-1:0])
    );

    logic cpu_hit, msg_hit, pend_match, accept;

    assign cpu_hit    = rd_vld[0] && (rd_tag[0] == cpu_tag);
    assign msg_hit    = rd_vld[1] && (rd_tag[1] == msg_tag);
    assign pend_match = (msg_tag == pend_tag) && (msg_idx == pend_idx);
    assign accept     = cpu_req_valid && (ctl_q.st == ST_IDLE);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.o_vld = 1'b0;
        ctl_d.r_vld = 1'b0;
        fill_en     = 1'b0;
        patch_en    = 1'b0;

        // processor side: only in idle
        if (accept) begin
            if (cpu_req_write) begin
                ctl_d.o_vld  = 1'b1;
                ctl_d.o_kind = OUT_WRITE;
                ctl_d.o_addr = cpu_req_addr;
                ctl_d.o_word = cpu_req_wdata;
                if (cpu_hit) begin
                    ctl_d.st   = ST_WRWAIT;
                    ctl_d.pend = cpu_req_addr;
                end else begin
                    ctl_d.r_vld = 1'b1;
                end
            end else if (cpu_hit) begin
                ctl_d.r_vld  = 1'b1;
                ctl_d.r_data = pick(rd_line[0], cpu_off);
            end else begin
                ctl_d.o_vld  = 1'b1;
                ctl_d.o_kind = OUT_READ;
                ctl_d.o_addr = cpu_req_addr;
                ctl_d.o_word = '0;
                ctl_d.st     = ST_RDWAIT;
                ctl_d.pend   = cpu_req_addr;
            end
        end

        // home side: one message per cycle, applied in arrival order
        if (home_msg_valid) begin
            case (home_msg_kind)
                IN_UPDATE: begin
                    patch_en = msg_hit;
                end
                IN_READREP: begin
                    if (ctl_q.st == ST_RDWAIT && pend_match) begin
                        fill_en      = 1'b1;
                        ctl_d.r_vld  = 1'b1;
                        ctl_d.r_data = pick(home_msg_data, pend_off);
                        ctl_d.st     = ST_IDLE;
                    end
                end
                IN_WRITEREP: begin
                    if (ctl_q.st == ST_WRWAIT && pend_match) begin
                        patch_en    = msg_hit;
                        ctl_d.r_vld = 1'b1;
                        ctl_d.st    = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_req_ready  = (ctl_q.st == ST_IDLE);
    assign cpu_rsp_valid  = ctl_q.r_vld;
    assign cpu_rsp_rdata  = ctl_q.r_data;
    assign home_req_valid = ctl_q.o_vld;
    assign home_req_kind  = ctl_q.o_kind;
    assign home_req_addr  = ctl_q.o_addr;
    assign home_req_word  = ctl_q.o_word;
endmodule

// File: rtl/wtu_cache_ctrl_chk.sv
module wtu_cache_ctrl_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINE_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_write,
    input logic [ADDR_W-1:0] cpu_req_addr,
    input logic [DATA_W-1:0] cpu_req_wdata,
    input logic              cpu_req_ready,
    input logic              cpu_rsp_valid,
    input logic              home_req_valid,
    input logic              home_req_kind,
    input logic [ADDR_W-1:0] home_req_addr,
    input logic [DATA_W-1:0] home_req_word,
    input logic              home_msg_valid,
    input logic [1:0]        home_msg_kind
);
    logic taken;
    assign taken = cpu_req_valid && cpu_req_ready;

    // R4: an outgoing request only follows an accepted processor request
    p_req_needs_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        home_req_valid |-> $past(taken));

    // R4: a write request carries the accepted store address and word
    p_write_carries_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (home_req_valid && home_req_kind) |->
            (home_req_word == $past(cpu_req_wdata) && home_req_addr == $past(cpu_req_addr) && $past(cpu_req_write)));

    // R3: after a read request the controller is busy
    p_read_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (home_req_valid && !home_req_kind) |-> !cpu_req_ready);

    // R10: a waiting controller stays waiting and silent until a message arrives
    p_wait_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req_ready && !home_msg_valid) |=> (!cpu_req_ready && !cpu_rsp_valid && !home_req_valid));

    // R6: a response follows an accepted request or a read/write reply
    p_rsp_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> ($past(taken) || $past(home_msg_valid && home_msg_kind != 2'd2)));

    // R9: incoming messages alone never produce an outgoing message
    p_silent_evict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (home_msg_valid && !taken) |=> !home_req_valid);
endmodule

bind wtu_cache_ctrl wtu_cache_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
    .home_req_valid(home_req_valid), .home_req_kind(home_req_kind),
    .home_req_addr(home_req_addr), .home_req_word(home_req_word),
    .home_msg_valid(home_msg_valid), .home_msg_kind(home_msg_kind)
);

// File: tb/sim_wtu_cache_ctrl.sv
module sim_wtu_cache_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int WORDS  = 4;
    localparam int LINES  = 8;
    localparam int LINE_W = WORDS * DATA_W;
    localparam int SPAN   = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic [DATA_W-1:0] cpu_req_wdata = '0;
    logic cpu_req_ready, cpu_rsp_valid;
    logic [DATA_W-1:0] cpu_rsp_rdata;
    logic home_req_valid, home_req_kind;
    logic [ADDR_W-1:0] home_req_addr;
    logic [DATA_W-1:0] home_req_word;
    logic home_msg_valid = 1'b0;
    logic [1:0] home_msg_kind = 2'd0;
    logic [ADDR_W-1:0] home_msg_addr = '0;
    logic [LINE_W-1:0] home_msg_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wtu_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES)) u0 (.*);

    int n_chk = 0, n_bad = 0;
    logic [DATA_W-1:0] mem [SPAN];
    logic              mvld [LINES];
    logic [ADDR_W-1:0] mblk [LINES];

    function automatic int idx_of(input logic [ADDR_W-1:0] a); return int'(a[4:2]); endfunction
    function automatic logic resident(input logic [ADDR_W-1:0] a);
        return mvld[idx_of(a)] && mblk[idx_of(a)] == (a >> 2);
    endfunction
    function automatic logic [LINE_W-1:0] block_of(input logic [ADDR_W-1:0] a);
        logic [LINE_W-1:0] b;
        for (int k = 0; k < WORDS; k++) b[k*DATA_W +: DATA_W] = mem[(int'(a) & ~3) + k];
        return b;
    endfunction

    task automatic check(input logic ok, input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic send_msg(input logic [1:0] k, input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] d);
        home_msg_valid = 1'b1; home_msg_kind = k; home_msg_addr = a; home_msg_data = d;
    endtask
    task automatic clear_msg(); home_msg_valid = 1'b0; endtask

    task automatic do_load(input logic [ADDR_W-1:0] a, input string tag);
        logic hit;
        hit = resident(a);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = a;
        tick();
        cpu_req_valid = 1'b0;
        if (hit) begin
            check(cpu_rsp_valid == 1'b1, tag, 32'(cpu_rsp_valid), 1);
            check(cpu_rsp_rdata == mem[a], tag, cpu_rsp_rdata, mem[a]);
            check(home_req_valid == 1'b0, tag, 32'(home_req_valid), 0);
        end else begin
            check(home_req_valid && home_req_kind == 1'b0, tag, {home_req_valid, home_req_kind}, 32'h2);
            check(home_req_addr[ADDR_W-1:2] == a[ADDR_W-1:2], tag, 32'(home_req_addr), 32'(a));
            check(cpu_rsp_valid == 1'b0, tag, 32'(cpu_rsp_valid), 0);
            repeat ($urandom_range(0, 3)) begin
                check(cpu_req_ready == 1'b0, "R3", 32'(cpu_req_ready), 0);
                tick();
            end
            send_msg(2'd0, a, block_of(a));
            tick();
            clear_msg();
            check(cpu_rsp_valid == 1'b1, tag, 32'(cpu_rsp_valid), 1);
            check(cpu_rsp_rdata == mem[a], tag, cpu_rsp_rdata, mem[a]);
            check(home_req_valid == 1'b0, "R9", 32'(home_req_valid), 0);
            mvld[idx_of(a)] = 1'b1;
            mblk[idx_of(a)] = a >> 2;
        end
    endtask

    task automatic do_store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic inject);
        logic hit;
        logic [ADDR_W-1:0] b;
        logic [DATA_W-1:0] e;
        hit = resident(a);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = a; cpu_req_wdata = d;
        tick();
        cpu_req_valid = 1'b0;
        check(home_req_valid && home_req_kind == 1'b1, "R4", {home_req_valid, home_req_kind}, 32'h3);
        check(home_req_addr == a && home_req_word == d, "R4", home_req_word, d);
        mem[a] = d;
        if (hit) begin
            check(cpu_rsp_valid == 1'b0 && cpu_req_ready == 1'b0, "R6", {cpu_rsp_valid, cpu_req_ready}, 0);
            if (inject) begin
                b = a ^ 12'd1;
                e = $urandom;
                send_msg(2'd2, b, LINE_W'(e));
                cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = b;
                tick();
                cpu_req_valid = 1'b0;
                clear_msg();
                mem[b] = e;
                check(cpu_req_ready == 1'b0 && cpu_rsp_valid == 1'b0 && home_req_valid == 1'b0,
                      "R10", {cpu_req_ready, cpu_rsp_valid, home_req_valid}, 0);
            end
            send_msg(2'd1, a, LINE_W'(d));
            tick();
            clear_msg();
            check(cpu_rsp_valid == 1'b1, "R6", 32'(cpu_rsp_valid), 1);
        end else begin
            check(cpu_rsp_valid == 1'b1 && cpu_req_ready == 1'b1, "R5", {cpu_rsp_valid, cpu_req_ready}, 3);
        end
    endtask

    task automatic do_update(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string tag);
        send_msg(2'd2, a, LINE_W'(d));
        tick();
        clear_msg();
        mem[a] = d;
        check(home_req_valid == 1'b0 && cpu_rsp_valid == 1'b0, tag, {home_req_valid, cpu_rsp_valid}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] old_v, new_v;
        void'($urandom(32'd152));
        for (int i = 0; i < SPAN; i++) mem[i] = $urandom;
        for (int i = 0; i < LINES; i++) begin mvld[i] = 1'b0; mblk[i] = '0; end
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        check(cpu_req_ready == 1'b1 && cpu_rsp_valid == 1'b0 && home_req_valid == 1'b0,
              "R1", {cpu_req_ready, cpu_rsp_valid, home_req_valid}, 32'h4);
        do_load(12'd5, "R1");                     // first access must miss
        do_load(12'd6, "R2");                     // same block now hits
        // R7: update one word of resident block, neighbours unchanged
        do_update(12'd5, 32'hA5A5_0007, "R7");
        do_load(12'd5, "R7");
        do_load(12'd4, "R7");
        do_load(12'd7, "R7");
        // R9: conflicting block evicts silently, old block misses again
        do_load(12'd37, "R9");
        do_load(12'd5, "R9");
        // R8: update to a non-resident block is dropped by the cache
        do_update(12'd40, 32'h0BAD_0040, "R8");
        do_load(12'd40, "R8");
        // R5: store miss allocates nothing
        do_store(12'd50, 32'h1234_5678, 1'b0);
        do_load(12'd50, "R5");
        // R6 and R10: store hit with an update during the wait
        do_store(12'd50, 32'h8765_4321, 1'b1);
        do_load(12'd50, "R6");
        do_load(12'd51, "R10");
        // R11: load hit and update to the same word in one cycle
        do_load(12'd49, "R11");
        old_v = mem[49];
        new_v = 32'hC0DE_0049;
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 12'd49;
        send_msg(2'd2, 12'd49, LINE_W'(new_v));
        tick();
        cpu_req_valid = 1'b0;
        clear_msg();
        check(cpu_rsp_valid == 1'b1 && cpu_rsp_rdata == old_v, "R11", cpu_rsp_rdata, old_v);
        mem[49] = new_v;
        do_load(12'd49, "R11");

        // constrained random mix
        for (int n = 0; n < 500; n++) begin
            logic [ADDR_W-1:0] a;
            int op;
            a  = ADDR_W'($urandom_range(0, SPAN - 1));
            op = $urandom_range(0, 9);
            if (op < 5)      do_load(a, "R2");
            else if (op < 8) do_store(a, $urandom, op == 7);
            else             do_update(a, $urandom, "R7");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule